// File: doc/BRIEF.md
# Windowed Injection Network Interface

This block connects one processing element to a packet-switched mesh router. Both directions pass through small flit buffers. Each message is a run of flits, and its final flit carries a last flag. The element-to-router path is rate-limited by a send window. A period of `PERIOD` clock cycles, called slots, repeats without pause. Within each period, a new message may begin only in a slot that the window grants. The flits that follow in the same message are never held back by the window.

A small register port reads and writes the settings at run time. The window count sets how many slots per period are granted. The mode bit selects where those slots fall. In block mode they form one run at the start of the period. In spread mode an accumulator places them evenly across the period. The interface also counts how often an incoming message had to wait at the router because the element-side input buffer was full. The counter saturates at its maximum, and a write to the counter's own address clears it.

Register addresses: 0 is the window count, 1 is the mode (bit 0 = 0 for block, 1 for spread), 2 is the stall counter (a read returns the count, a write clears it), and 3 reads as zero. Control reads are combinational. Writes take effect at the clock edge that samples `ctl_wr`.

Top module: `inj_window_ni`

## Requirements
- R1: Flits pass through a `DEPTH`-entry buffer in each direction, in order, with their last flags. Each buffered flit appears at the output one cycle after it is accepted. `pe_tx_ready` is low while the outbound buffer is full, and `rt_rx_ready` is low while the inbound buffer is full. An offered outbound flit stays valid and unchanged until the router accepts it.
- R2: In block mode, with window W, a message may begin only in slots 0 to W-1 of each period.
- R3: In spread mode, each slot adds W to an accumulator. A slot is granted when the sum reaches `PERIOD` or more, and `PERIOD` is then subtracted. This gives exactly W grants per period.
- R4: A write to the window or mode register restarts the period. The cycle right after the write edge is slot 0, and the accumulator is cleared to zero.
- R5: With window 0, no message starts. With window equal to `PERIOD`, every slot is granted, so a backlog drains at one single-flit message per cycle.
- R6: A window write larger than `PERIOD` stores `PERIOD`. The window register reads back its stored value, and the mode register reads back its bit.
- R7: Once a message's first flit is sent, its remaining flits are sent in the next cycles, provided they are buffered and the router is ready, even if the window has closed.
- R8: An incoming first flit that is refused because the inbound buffer is full adds exactly one to the stall counter, however many cycles it waits.
- R9: The stall counter stops at 2^`STAT_W`-1 and does not wrap.
- R10: A write to address 2 sets the stall counter to 0 at that edge.
- R11: After reset, both output valids are low, both readys are high, the window is `PERIOD`, the mode is block and the stall counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pe_tx_valid | input | 1 | Element offers an outbound flit |
| pe_tx_ready | output | 1 | Outbound buffer has room |
| pe_tx_data | input | FLIT_W | Outbound flit payload |
| pe_tx_last | input | 1 | Outbound flit ends its message |
| rt_tx_valid | output | 1 | Flit offered to the router |
| rt_tx_ready | input | 1 | Router accepts the flit |
| rt_tx_data | output | FLIT_W | Flit payload to the router |
| rt_tx_last | output | 1 | Flit ends its message |
| rt_rx_valid | input | 1 | Router offers an inbound flit |
| rt_rx_ready | output | 1 | Inbound buffer has room |
| rt_rx_data | input | FLIT_W | Inbound flit payload |
| rt_rx_last | input | 1 | Inbound flit ends its message |
| pe_rx_valid | output | 1 | Inbound flit available to the element |
| pe_rx_ready | input | 1 | Element takes the flit |
| pe_rx_data | output | FLIT_W | Inbound flit payload |
| pe_rx_last | output | 1 | Inbound flit ends its message |
| ctl_wr | input | 1 | Register write strobe |
| ctl_addr | input | 2 | Register address |
| ctl_wdata | input | CTL_W | Register write data |
| ctl_rdata | output | CTL_W | Register read data, combinational |

## Verification
Each window setting is written at one clock edge, so the first slot of the new period is the cycle that follows that edge. The bench samples `rt_tx_valid` at each falling edge from that cycle onward, `PERIOD` times, and records the count, first slot and last slot of the starts it sees. A buffered flit reaches its output one cycle after acceptance, so the drain and message-continuation checks expect the next flit in the cycle after each handshake. The stall counter changes at the edge where a refused first flit is first seen, and a clear takes effect at the write edge. Its value is therefore read through the combinational register port at the falling edge after those edges.

// File: rtl/ni_pkg.sv
`timescale 1ns/1ps
package ni_pkg;

    typedef enum logic [1:0] {
        CA_WINDOW  = 2'd0,
        CA_MODE    = 2'd1,
        CA_BLOCKED = 2'd2,
        CA_SPARE   = 2'd3
    } ctl_addr_e;

    typedef enum logic {
        WM_BLOCK  = 1'b0,
        WM_SPREAD = 1'b1
    } win_mode_e;

endpackage

// File: rtl/ni_fifo.sv
`timescale 1ns/1ps
// Synchronous flit buffer; DEPTH must be a power of two, at least 2.
module ni_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push, pop;

    assign in_ready  = (st_q.cnt != CW'(DEPTH));
    assign out_valid = (st_q.cnt != '0);
    assign out_data  = st_q.mem[st_q.rp];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = in_data;
            st_d.wp           = st_q.wp + PW'(1);
        end
        if (pop) begin
            st_d.rp = st_q.rp + PW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ni_window.sv
`timescale 1ns/1ps
// Slot grant generator: block or evenly spread allocation per period.
module ni_window #(
    parameter int PERIOD = 256,
    localparam int WIN_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  ni_pkg::win_mode_e mode,
    input  logic [WIN_W-1:0]  win,
    output logic              grant
);
    import ni_pkg::*;

    localparam int POS_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int ACC_W = $clog2(2 * PERIOD + 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [ACC_W-1:0] acc;
    } win_st_t;

    win_st_t          st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic             g_block, g_spread;

    always_comb begin
        sum      = st_q.acc + ACC_W'(win);
        g_spread = (sum >= ACC_W'(PERIOD));
        g_block  = (WIN_W'(st_q.pos) < win);
        grant    = (mode == WM_SPREAD) ? g_spread : g_block;

        st_d = st_q;
        if (st_q.pos == POS_W'(PERIOD - 1)) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + POS_W'(1);
        end
        st_d.acc = g_spread ? (sum - ACC_W'(PERIOD)) : sum;
        if (restart) begin
            st_d.pos = '0;
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ni_blkstat.sv
`timescale 1ns/1ps
// Saturating counter of inbound messages stalled at the router.
module ni_blkstat #(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    input  logic              clear,
    output logic [STAT_W-1:0] count
);
    localparam logic [STAT_W-1:0] CNT_MAX = {STAT_W{1'b1}};

    logic [STAT_W-1:0] cnt_d, cnt_q;

    assign count = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (bump && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + STAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/inj_window_ni.sv
`timescale 1ns/1ps
module inj_window_ni #(
    parameter int FLIT_W = 32,
    parameter int DEPTH  = 4,
    parameter int PERIOD = 256,
    parameter int STAT_W = 16,
    parameter int CTL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_tx_valid,
    output logic              pe_tx_ready,
    input  logic [FLIT_W-1:0] pe_tx_data,
    input  logic              pe_tx_last,
    output logic              rt_tx_valid,
    input  logic              rt_tx_ready,
    output logic [FLIT_W-1:0] rt_tx_data,
    output logic              rt_tx_last,
    input  logic              rt_rx_valid,
    output logic              rt_rx_ready,
    input  logic [FLIT_W-1:0] rt_rx_data,
    input  logic              rt_rx_last,
    output logic              pe_rx_valid,
    input  logic              pe_rx_ready,
    output logic [FLIT_W-1:0] pe_rx_data,
    output logic              pe_rx_last,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_addr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata
);
    import ni_pkg::*;

    localparam int WIN_W = $clog2(PERIOD + 1);
    localparam int FW    = FLIT_W + 1;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        win_mode_e        mode;
        logic             tx_in_msg;
        logic             tx_credit;
        logic             rx_in_msg;
        logic             rx_seen;
    } ni_st_t;

    ni_st_t st_d, st_q;

    // Outbound buffer
    logic          txf_valid, txf_pop;
    logic [FW-1:0] txf_data;

    ni_fifo #(.W(FW), .DEPTH(DEPTH)) u_txf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pe_tx_valid),
        .in_ready  (pe_tx_ready),
        .in_data   ({pe_tx_last, pe_tx_data}),
        .out_valid (txf_valid),
        .out_ready (txf_pop),
        .out_data  (txf_data)
    );

    // Inbound buffer
    logic [FW-1:0] rxf_data;

    ni_fifo #(.W(FW), .DEPTH(DEPTH)) u_rxf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rt_rx_valid),
        .in_ready  (rt_rx_ready),
        .in_data   ({rt_rx_last, rt_rx_data}),
        .out_valid (pe_rx_valid),
        .out_ready (pe_rx_ready),
        .out_data  (rxf_data)
    );

    assign pe_rx_data = rxf_data[FLIT_W-1:0];
    assign pe_rx_last = rxf_data[FLIT_W];

    // Slot window
    logic             wr_win, wr_mode, wr_clr, restart, grant;
    logic [WIN_W-1:0] win_cur;
    logic             tx_credit_cur, tx_in_msg_cur;

    assign win_cur       = st_q.win;
    assign tx_credit_cur = st_q.tx_credit;
    assign tx_in_msg_cur = st_q.tx_in_msg;

    ni_window #(.PERIOD(PERIOD)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .mode    (st_q.mode),
        .win     (st_q.win),
        .grant   (grant)
    );

    // Stall statistics
    logic              head_wait;
    logic [STAT_W-1:0] blk_cnt;

    ni_blkstat #(.STAT_W(STAT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (head_wait),
        .clear (wr_clr),
        .count (blk_cnt)
    );

    // Egress gating
    logic tx_go;

    assign tx_go       = st_q.tx_in_msg || st_q.tx_credit || grant;
    assign rt_tx_valid = txf_valid && tx_go;
    assign rt_tx_data  = txf_data[FLIT_W-1:0];
    assign rt_tx_last  = txf_data[FLIT_W];
    assign txf_pop     = rt_tx_valid && rt_tx_ready;

    assign wr_win    = ctl_wr && (ctl_addr == CA_WINDOW);
    assign wr_mode   = ctl_wr && (ctl_addr == CA_MODE);
    assign wr_clr    = ctl_wr && (ctl_addr == CA_BLOCKED);
    assign restart   = wr_win || wr_mode;
    assign head_wait = rt_rx_valid && !rt_rx_ready && !st_q.rx_in_msg && !st_q.rx_seen;

    always_comb begin
        st_d = st_q;

        // message boundary tracking and start credit
        if (txf_pop) begin
            st_d.tx_in_msg = !rt_tx_last;
        end
        if (txf_pop && !st_q.tx_in_msg) begin
            st_d.tx_credit = 1'b0;
        end else if (grant && txf_valid && !st_q.tx_in_msg) begin
            st_d.tx_credit = 1'b1;
        end

        // inbound head stall tracking
        if (rt_rx_valid && rt_rx_ready) begin
            st_d.rx_in_msg = !rt_rx_last;
            st_d.rx_seen   = 1'b0;
        end else if (head_wait) begin
            st_d.rx_seen = 1'b1;
        end

        // control writes
        if (wr_win) begin
            if (ctl_wdata > CTL_W'(PERIOD)) begin
                st_d.win = WIN_W'(PERIOD);
            end else begin
                st_d.win = ctl_wdata[WIN_W-1:0];
            end
        end
        if (wr_mode) begin
            st_d.mode = win_mode_e'(ctl_wdata[0]);
        end
    end

    always_comb begin
        case (ctl_addr)
            CA_WINDOW:  ctl_rdata = CTL_W'(st_q.win);
            CA_MODE:    ctl_rdata = CTL_W'(st_q.mode);
            CA_BLOCKED: ctl_rdata = CTL_W'(blk_cnt);
            default:    ctl_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.win  <= WIN_W'(PERIOD);
            st_q.mode <= WM_BLOCK;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ni_checker.sv
`timescale 1ns/1ps
module ni_checker #(
    parameter int PERIOD = 256,
    parameter int STAT_W = 16,
    parameter int FLIT_W = 32,
    localparam int WIN_W = $clog2(PERIOD + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rt_tx_valid,
    input logic              rt_tx_ready,
    input logic [FLIT_W-1:0] rt_tx_data,
    input logic              pe_rx_valid,
    input logic              pe_rx_ready,
    input logic [FLIT_W-1:0] pe_rx_data,
    input logic              ctl_wr,
    input logic [1:0]        ctl_addr,
    input logic [WIN_W-1:0]  win_cur,
    input logic              tx_credit_cur,
    input logic              tx_in_msg_cur,
    input logic [STAT_W-1:0] blk_cnt
);
    localparam logic [STAT_W-1:0] CNT_MAX = {STAT_W{1'b1}};

    p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_tx_valid && !rt_tx_ready) |=> (rt_tx_valid && $stable(rt_tx_data)));

    p_rx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_rx_valid && !pe_rx_ready) |=> (pe_rx_valid && $stable(pe_rx_data)));

    p_zero_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cur == '0 && !tx_credit_cur && !tx_in_msg_cur) |-> !rt_tx_valid);

    p_window_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_cur <= WIN_W'(PERIOD));

    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && ctl_addr == 2'd2) |=>
            (blk_cnt == $past(blk_cnt) || blk_cnt == $past(blk_cnt) + STAT_W'(1)));

    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_cnt == CNT_MAX && !(ctl_wr && ctl_addr == 2'd2)) |=> blk_cnt == CNT_MAX);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_addr == 2'd2) |=> blk_cnt == '0);
endmodule

bind inj_window_ni ni_checker #(
    .PERIOD (PERIOD),
    .STAT_W (STAT_W),
    .FLIT_W (FLIT_W)
) u_ni_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rt_tx_valid   (rt_tx_valid),
    .rt_tx_ready   (rt_tx_ready),
    .rt_tx_data    (rt_tx_data),
    .pe_rx_valid   (pe_rx_valid),
    .pe_rx_ready   (pe_rx_ready),
    .pe_rx_data    (pe_rx_data),
    .ctl_wr        (ctl_wr),
    .ctl_addr      (ctl_addr),
    .win_cur       (win_cur),
    .tx_credit_cur (tx_credit_cur),
    .tx_in_msg_cur (tx_in_msg_cur),
    .blk_cnt       (blk_cnt)
);

// File: tb/test_inj_window_ni.sv
`timescale 1ns/1ps
module test_inj_window_ni;
    localparam int FLIT_W = 8;
    localparam int DEPTH  = 4;
    localparam int PERIOD = 16;
    localparam int STAT_W = 3;
    localparam int CTL_W  = 8;
    localparam int NONE   = 63;

    typedef struct packed {
        logic       mode;
        logic [7:0] win;
        logic [5:0] cnt;
        logic [5:0] first;
        logic [5:0] last;
    } vec_t;

    // mode, window written, expected starts, first slot, last slot
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'd4,  6'd4,  6'd0,  6'd3},
        '{1'b1, 8'd4,  6'd4,  6'd3,  6'd15},
        '{1'b1, 8'd16, 6'd16, 6'd0,  6'd15},
        '{1'b0, 8'd0,  6'd0,  6'd63, 6'd63},
        '{1'b1, 8'd3,  6'd3,  6'd5,  6'd15},
        '{1'b0, 8'd16, 6'd16, 6'd0,  6'd15},
        '{1'b0, 8'd20, 6'd16, 6'd0,  6'd15},
        '{1'b1, 8'd8,  6'd8,  6'd1,  6'd15},
        '{1'b1, 8'd0,  6'd0,  6'd63, 6'd63}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pe_tx_valid = 1'b0;
    logic              pe_tx_ready;
    logic [FLIT_W-1:0] pe_tx_data = '0;
    logic              pe_tx_last = 1'b1;
    logic              rt_tx_valid;
    logic              rt_tx_ready = 1'b1;
    logic [FLIT_W-1:0] rt_tx_data;
    logic              rt_tx_last;
    logic              rt_rx_valid = 1'b0;
    logic              rt_rx_ready;
    logic [FLIT_W-1:0] rt_rx_data = '0;
    logic              rt_rx_last = 1'b1;
    logic              pe_rx_valid;
    logic              pe_rx_ready = 1'b0;
    logic [FLIT_W-1:0] pe_rx_data;
    logic              pe_rx_last;
    logic              ctl_wr = 1'b0;
    logic [1:0]        ctl_addr = 2'd0;
    logic [CTL_W-1:0]  ctl_wdata = '0;
    logic [CTL_W-1:0]  ctl_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    inj_window_ni #(
        .FLIT_W (FLIT_W),
        .DEPTH  (DEPTH),
        .PERIOD (PERIOD),
        .STAT_W (STAT_W),
        .CTL_W  (CTL_W)
    ) i_inj_window_ni (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [1:0] a, input int v);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_addr  = a;
        ctl_wdata = CTL_W'(v);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic ctl_read(input logic [1:0] a, output int v);
        ctl_addr = a;
        #1;
        v = int'(ctl_rdata);
    endtask

    task automatic rx_send(input int d);
        @(negedge clk);
        rt_rx_valid = 1'b1;
        rt_rx_data  = FLIT_W'(d);
        rt_rx_last  = 1'b1;
        while (!rt_rx_ready) @(negedge clk);
        @(negedge clk);
        rt_rx_valid = 1'b0;
    endtask

    // one refused head, one element pop, then the head is taken
    task automatic rx_stall_once(input int d);
        @(negedge clk);
        rt_rx_valid = 1'b1;
        rt_rx_data  = FLIT_W'(d);
        @(negedge clk);
        pe_rx_ready = 1'b1;
        @(negedge clk);
        pe_rx_ready = 1'b0;
        @(negedge clk);
        rt_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rv, n, first, last, exp_win;
        logic [FLIT_W-1:0] msg [3];
        msg[0] = 8'hA1; msg[1] = 8'hB2; msg[2] = 8'hC3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // ---- vector table: window placement per mode
        pe_tx_valid = 1'b1;
        pe_tx_last  = 1'b1;
        pe_tx_data  = 8'h5A;
        rt_tx_ready = 1'b1;
        for (int v = 0; v < NV; v++) begin
            ctl_write(2'd0, 0);
            repeat (6) @(negedge clk);
            chk("R1 outbound full backpressure", int'(pe_tx_ready), 0);
            chk("R5 zero window holds backlog", int'(rt_tx_valid), 0);
            ctl_write(2'd1, int'(VEC[v].mode));
            ctl_write(2'd0, int'(VEC[v].win));
            n = 0; first = NONE; last = NONE;
            for (int k = 0; k < PERIOD; k++) begin
                if (rt_tx_valid) begin
                    if (first == NONE) first = k;
                    last = k;
                    n++;
                end
                @(negedge clk);
            end
            chk(VEC[v].mode ? "R3 spread start count" : "R2 block start count", n, int'(VEC[v].cnt));
            chk(VEC[v].mode ? "R3 spread first slot R4" : "R2 block first slot R4", first, int'(VEC[v].first));
            chk(VEC[v].mode ? "R3 spread last slot" : "R2 block last slot", last, int'(VEC[v].last));
            exp_win = (int'(VEC[v].win) > PERIOD) ? PERIOD : int'(VEC[v].win);
            ctl_read(2'd0, rv);
            chk("R6 window readback", rv, exp_win);
            ctl_read(2'd1, rv);
            chk("R6 mode readback", rv, int'(VEC[v].mode));
        end
        chk("R5 full window unthrottled", int'(VEC[5].cnt), PERIOD);

        // ---- R7: multi-flit message continues after window closes
        pe_tx_valid = 1'b0;
        ctl_write(2'd1, 0);
        ctl_write(2'd0, PERIOD);
        repeat (8) @(negedge clk);
        ctl_write(2'd0, 0);
        for (int f = 0; f < 3; f++) begin
            @(negedge clk);
            pe_tx_valid = 1'b1;
            pe_tx_data  = msg[f];
            pe_tx_last  = (f == 2);
        end
        @(negedge clk);
        pe_tx_valid = 1'b0;
        ctl_write(2'd0, 1);
        for (int k = 0; k < PERIOD; k++) begin
            chk("R7 message flit valid", int'(rt_tx_valid), (k < 3) ? 1 : 0);
            if (k < 3) begin
                chk("R7 message flit data", int'(rt_tx_data), int'(msg[k]));
                chk("R7 message flit last", int'(rt_tx_last), (k == 2) ? 1 : 0);
            end
            @(negedge clk);
        end

        // ---- inbound buffer and stall counting
        pe_rx_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) rx_send(10 + i);
        chk("R1 inbound full backpressure", int'(rt_rx_ready), 0);
        ctl_read(2'd2, rv);
        chk("R8 no stall yet", rv, 0);
        @(negedge clk);
        rt_rx_valid = 1'b1;
        rt_rx_data  = 8'd14;
        rt_rx_last  = 1'b1;
        repeat (5) @(negedge clk);
        ctl_read(2'd2, rv);
        chk("R8 long stall counted once", rv, 1);
        pe_rx_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            bit taking;
            taking = rt_rx_valid && rt_rx_ready;
            chk("R1 inbound order valid", int'(pe_rx_valid), 1);
            chk("R1 inbound order data", int'(pe_rx_data), 10 + i);
            chk("R1 inbound last flag", int'(pe_rx_last), 1);
            @(negedge clk);
            if (taking) rt_rx_valid = 1'b0;
        end
        chk("R1 inbound drained", int'(pe_rx_valid), 0);
        ctl_read(2'd2, rv);
        chk("R8 unstalled traffic not counted", rv, 1);

        // ---- R9 saturation
        pe_rx_ready = 1'b0;
        for (int i = 0; i < DEPTH; i++) rx_send(20 + i);
        for (int i = 0; i < 6; i++) rx_stall_once(30 + i);
        ctl_read(2'd2, rv);
        chk("R8 one per stalled message", rv, 7);
        rx_stall_once(40);
        ctl_read(2'd2, rv);
        chk("R9 counter saturates", rv, 7);

        // ---- R10 clear
        ctl_write(2'd2, 0);
        ctl_read(2'd2, rv);
        chk("R10 clear by write", rv, 0);
        ctl_read(2'd3, rv);
        chk("R6 spare address reads zero", rv, 0);

        // ---- R11 reset state
        @(negedge clk);
        rst_n = 1'b0;
        pe_rx_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rt_tx_valid", int'(rt_tx_valid), 0);
        chk("R11 pe_rx_valid", int'(pe_rx_valid), 0);
        chk("R11 pe_tx_ready", int'(pe_tx_ready), 1);
        chk("R11 rt_rx_ready", int'(rt_rx_ready), 1);
        ctl_read(2'd0, rv);
        chk("R11 window", rv, PERIOD);
        ctl_read(2'd1, rv);
        chk("R11 mode", rv, 0);
        ctl_read(2'd2, rv);
        chk("R11 stall counter", rv, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule